// File: doc/BRIEF.md
# Auto-Baud Sync Character Detector

This block measures the bit period of a single-wire, UART-style receive line from the sync character that opens every transaction. A fast local clock oversamples the line, which is already synchronised and idles high. Each character has a low start bit, eight data bits sent least significant bit first, and a high stop bit. The sync character is 0x55, so after the start bit the line alternates 1,0,1,0,1,0,1,0. The block measures each interval between the alternating edges. It checks that the intervals agree and derives a bit-period count in fast-clock cycles.

The block re-measures on every sync character, so slow drift between the two clocks is cancelled per transaction. When the stop bit is confirmed high at its mid-point, the block presents the new period together with a one-cycle valid strobe. A downstream byte receiver uses that count to time the bytes that follow. A malformed sync character raises a one-cycle error strobe instead. The block then re-arms only after it has seen the line high again. `MIN_PERIOD` must be at least 4.

Top module: `autobaud_sync`

## Requirements
- R1: After reset `bit_period` is 0 and `period_valid` and `sync_err` are low; an idle-high line produces no strobe.
- R2: The measured period equals floor(S/8), where S is the number of clock cycles from the start-bit falling edge to the eighth edge after it. That eighth edge is the falling edge that opens data bit 7.
- R3: On an accepted sync character, `period_valid` is high for exactly one cycle and `bit_period` carries the new period in that cycle. With uniform bits of N cycles, the strobe is visible after the clock edge that comes 8N + N + floor(N/2) edges after the edge that first samples the start bit low.
- R4: If any of the eight intervals differs from the period by more than floor(period/4), `sync_err` pulses, no valid strobe is given, and `bit_period` keeps its previous value.
- R5: During measurement, an edge-free gap that reaches 2^CNT_W − 1 cycles raises `sync_err`, and the counter does not wrap. A line stuck low after a start bit is the case this covers.
- R6: A stop bit sampled low at period + floor(period/2) cycles after the bit-7 edge raises `sync_err` instead of `period_valid`.
- R7: A data bit 7 sampled high at floor(period/2) cycles after its opening edge raises `sync_err`.
- R8: A measured period below `MIN_PERIOD` raises `sync_err`, and no valid strobe is given.
- R9: After an error the block waits for the line to be high, and only a later falling edge starts a new measurement. A correct sync character after a stuck-low line is then accepted.
- R10: Every sync character is measured afresh, and a new accepted period replaces the old one.
- R11: `period_valid` and `sync_err` are never high in the same cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Synchronised receive line, idle high |
| bit_period | output | CNT_W | Last accepted bit period in clock cycles |
| period_valid | output | 1 | One-cycle strobe when a new period is accepted |
| sync_err | output | 1 | One-cycle strobe when a sync character is rejected |

## Verification
The hardest situations to reach from the ports are the late rejections. In these, every edge interval is acceptable, but the line is wrong at a mid-bit sample taken after measurement has finished. The bench builds sync characters segment by segment with individually chosen lengths. It can therefore cut data bit 7 short or hold the stop bit low while the eight measured intervals stay exact. The saturation path is reached by holding the line low past the counter limit, using a narrow counter width on the bench instance.

// File: rtl/autobaud_pkg.sv
`timescale 1ns/1ps
package autobaud_pkg;

    // number of timed intervals in the sync character (start bit + data bits 0..6)
    localparam int SYNC_EDGES = 8;
    localparam int EDGE_IDX_W = $clog2(SYNC_EDGES);
    localparam int AVG_SHIFT  = $clog2(SYNC_EDGES);

    typedef enum logic [2:0] {
        AB_IDLE,
        AB_MEASURE,
        AB_CHECK,
        AB_TAIL,
        AB_HUNT
    } ab_state_e;

    typedef struct packed {
        logic level;
        logic toggled;
        logic fell;
    } ab_line_t;

    typedef struct packed {
        logic deviate;
        logic too_short;
    } ab_verdict_t;

    // true when iv lies within per +/- floor(per/4)
    function automatic logic within_quarter(input logic [31:0] iv, input logic [31:0] per);
        logic [31:0] slack;
        slack = per >> 2;
        return ((iv + slack) >= per) && (iv <= (per + slack));
    endfunction

endpackage

// File: rtl/ab_edge_timer.sv
`timescale 1ns/1ps
module ab_edge_timer
    import autobaud_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rx,
    input  logic           restart,
    output ab_line_t       line,
    output logic [CNT_W:0] cnt
);

    localparam logic [CNT_W:0] CNT_TOP = '1;

    logic rx_q;

    always_ff @(posedge clk) begin
        if (rst) rx_q <= 1'b1;
        else     rx_q <= rx;
    end

    always_comb begin
        line.level   = rx;
        line.toggled = rx ^ rx_q;
        line.fell    = rx_q & ~rx;
    end

    // saturating cycle counter, reloaded to 1 on each timed edge
    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (restart)        cnt <= (CNT_W+1)'(1);
        else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ab_interval_bank.sv
`timescale 1ns/1ps
module ab_interval_bank
    import autobaud_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int MIN_PERIOD = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  store,
    input  logic [EDGE_IDX_W-1:0] idx,
    input  logic [CNT_W-1:0]      iv_in,
    output logic [CNT_W-1:0]      period,
    output ab_verdict_t           verdict
);

    localparam int TOT_W = CNT_W + AVG_SHIFT;

    logic [TOT_W-1:0]      total;
    logic [SYNC_EDGES-1:0] dev;

    always_ff @(posedge clk) begin
        if (rst || clear) total <= '0;
        else if (store)   total <= total + TOT_W'(iv_in);
    end

    assign period = total[TOT_W-1:AVG_SHIFT];

    for (genvar g = 0; g < SYNC_EDGES; g++) begin : g_slot
        logic [CNT_W-1:0] iv_q;
        always_ff @(posedge clk) begin
            if (rst)                                    iv_q <= '0;
            else if (store && idx == EDGE_IDX_W'(g))    iv_q <= iv_in;
        end
        assign dev[g] = !within_quarter(32'(iv_q), 32'(period));
    end

    always_comb begin
        verdict.deviate   = |dev;
        verdict.too_short = period < CNT_W'(MIN_PERIOD);
    end

endmodule

// File: rtl/ab_sync_fsm.sv
`timescale 1ns/1ps
module ab_sync_fsm
    import autobaud_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ab_line_t              line,
    input  logic [CNT_W:0]        cnt,
    input  logic [CNT_W-1:0]      period,
    input  ab_verdict_t           verdict,
    output logic                  restart,
    output logic                  clear,
    output logic                  store,
    output logic [EDGE_IDX_W-1:0] idx,
    output logic                  accept,
    output logic                  lock,
    output logic                  fault
);

    localparam logic [CNT_W:0]        IV_LIMIT  = {1'b0, {CNT_W{1'b1}}};
    localparam logic [EDGE_IDX_W-1:0] LAST_EDGE = EDGE_IDX_W'(SYNC_EDGES - 1);

    ab_state_e             state, nxt;
    logic [EDGE_IDX_W-1:0] edge_q;
    logic [CNT_W:0]        half_pt, stop_pt;
    logic                  fail;

    assign half_pt = {1'b0, period} >> 1;
    assign stop_pt = {1'b0, period} + half_pt;
    assign idx     = edge_q;

    always_comb begin
        nxt     = state;
        restart = 1'b0;
        clear   = 1'b0;
        store   = 1'b0;
        accept  = 1'b0;
        fail    = 1'b0;
        unique case (state)
            AB_IDLE: begin
                if (line.fell) begin
                    restart = 1'b1;
                    clear   = 1'b1;
                    nxt     = AB_MEASURE;
                end
            end
            AB_MEASURE: begin
                if (cnt >= IV_LIMIT) begin
                    fail = 1'b1;
                    nxt  = AB_HUNT;
                end else if (line.toggled) begin
                    restart = 1'b1;
                    store   = 1'b1;
                    if (edge_q == LAST_EDGE) nxt = AB_CHECK;
                end
            end
            AB_CHECK: begin
                if (verdict.deviate || verdict.too_short) begin
                    fail = 1'b1;
                    nxt  = AB_HUNT;
                end else begin
                    nxt = AB_TAIL;
                end
            end
            AB_TAIL: begin
                if (cnt == half_pt && line.level) begin
                    fail = 1'b1;
                    nxt  = AB_HUNT;
                end else if (cnt == stop_pt) begin
                    if (line.level) begin
                        accept = 1'b1;
                        nxt    = AB_IDLE;
                    end else begin
                        fail = 1'b1;
                        nxt  = AB_HUNT;
                    end
                end
            end
            AB_HUNT: begin
                if (line.level) nxt = AB_IDLE;
            end
            default: nxt = AB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= AB_IDLE;
            edge_q <= '0;
            lock   <= 1'b0;
            fault  <= 1'b0;
        end else begin
            state <= nxt;
            lock  <= accept;
            fault <= fail;
            if (clear)      edge_q <= '0;
            else if (store) edge_q <= edge_q + 1'b1;
        end
    end

endmodule

// File: rtl/autobaud_sync.sv
`timescale 1ns/1ps
module autobaud_sync
    import autobaud_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int MIN_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx,
    output logic [CNT_W-1:0] bit_period,
    output logic             period_valid,
    output logic             sync_err
);

    ab_line_t              line;
    ab_verdict_t           verdict;
    logic [CNT_W:0]        cnt;
    logic [CNT_W-1:0]      period;
    logic [EDGE_IDX_W-1:0] idx;
    logic                  restart, clear, store, accept;

    ab_edge_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .rx      (rx),
        .restart (restart),
        .line    (line),
        .cnt     (cnt)
    );

    ab_interval_bank #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .store   (store),
        .idx     (idx),
        .iv_in   (cnt[CNT_W-1:0]),
        .period  (period),
        .verdict (verdict)
    );

    ab_sync_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .line    (line),
        .cnt     (cnt),
        .period  (period),
        .verdict (verdict),
        .restart (restart),
        .clear   (clear),
        .store   (store),
        .idx     (idx),
        .accept  (accept),
        .lock    (period_valid),
        .fault   (sync_err)
    );

    always_ff @(posedge clk) begin
        if (rst)         bit_period <= '0;
        else if (accept) bit_period <= period;
    end

endmodule

// File: rtl/autobaud_sync_chk.sv
`timescale 1ns/1ps
module autobaud_sync_chk #(
    parameter int CNT_W      = 16,
    parameter int MIN_PERIOD = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rx,
    input logic [CNT_W-1:0] bit_period,
    input logic             period_valid,
    input logic             sync_err
);

    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(period_valid && sync_err));

    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        period_valid |=> !period_valid);

    p_err_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !sync_err);

    p_stop_high_r6: assert property (@(posedge clk) disable iff (rst)
        period_valid |-> $past(rx));

    p_min_period_r8: assert property (@(posedge clk) disable iff (rst)
        period_valid |-> (bit_period >= CNT_W'(MIN_PERIOD)));

    p_period_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_period != $past(bit_period)) |-> period_valid);

endmodule

bind autobaud_sync autobaud_sync_chk #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx           (rx),
    .bit_period   (bit_period),
    .period_valid (period_valid),
    .sync_err     (sync_err)
);

// File: tb/autobaud_sync_test.sv
`timescale 1ns/1ps
module autobaud_sync_test;

    localparam int CNT_W = 10;
    localparam int MIN_P = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx  = 1'b1;
    logic [CNT_W-1:0] bit_period;
    logic             period_valid;
    logic             sync_err;

    always #2 clk = ~clk;

    autobaud_sync #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_P)) uut (
        .clk          (clk),
        .rst          (rst),
        .rx           (rx),
        .bit_period   (bit_period),
        .period_valid (period_valid),
        .sync_err     (sync_err)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int               n_valid = 0, n_err = 0, n_both = 0, last_cyc = 0, start_cyc = 0;
    logic [CNT_W-1:0] seen_period = '0;
    int               n_chk = 0, n_fail = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (period_valid) begin
                n_valid++;
                seen_period = bit_period;
                last_cyc    = cyc;
            end
            if (sync_err) n_err++;
            if (period_valid && sync_err) n_both++;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic seg(input logic lvl, input int n);
        rx = lvl;
        repeat (n) @(negedge clk);
    endtask

    // start bit + data bits 0..6 of the sync character
    task automatic send_body(input int iv[8]);
        start_cyc = cyc;
        seg(1'b0, iv[0]);
        for (int k = 1; k < 8; k++) seg((k % 2 == 1) ? 1'b1 : 1'b0, iv[k]);
    endtask

    task automatic send_uniform(input int n);
        int iv[8];
        foreach (iv[i]) iv[i] = n;
        send_body(iv);
        seg(1'b0, n);
        seg(1'b1, n);
        seg(1'b1, 2 * n);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(bit_period == '0, "R1 reset bit_period", bit_period, 0);
        check(!period_valid && !sync_err, "R1 reset strobes", {period_valid, sync_err}, 0);
        rst = 1'b0;
        seg(1'b1, 100);
        check(n_valid == 0 && n_err == 0, "R1 idle no strobe", n_valid + n_err, 0);
    endtask

    task automatic t_basic;
        int v0 = n_valid, e0 = n_err;
        send_uniform(16);
        check(n_valid - v0 == 1, "R3 one valid strobe", n_valid - v0, 1);
        check(n_err == e0, "R3 no error", n_err - e0, 0);
        check(seen_period == 16, "R2 period N=16", seen_period, 16);
        check(last_cyc - start_cyc == 153, "R3 strobe latency N=16", last_cyc - start_cyc, 153);
    endtask

    task automatic t_retime;
        int v0 = n_valid;
        send_uniform(10);
        check(n_valid - v0 == 1, "R10 remeasure strobe", n_valid - v0, 1);
        check(seen_period == 10, "R10 new period N=10", seen_period, 10);
        check(last_cyc - start_cyc == 96, "R3 strobe latency N=10", last_cyc - start_cyc, 96);
    endtask

    task automatic t_uneven;
        int v0 = n_valid, e0 = n_err;
        int iv[8] = '{18, 14, 17, 15, 16, 19, 13, 18};
        send_body(iv);
        seg(1'b0, 16);
        seg(1'b1, 40);
        check(n_valid - v0 == 1 && n_err == e0, "R2 uneven accepted", n_valid - v0, 1);
        check(bit_period == 16, "R2 floor(130/8)", bit_period, 16);
    endtask

    task automatic t_tol;
        int v0 = n_valid, e0 = n_err;
        int iv[8] = '{16, 16, 16, 21, 16, 16, 16, 16};
        send_body(iv);
        seg(1'b0, 16);
        seg(1'b1, 40);
        check(n_err - e0 == 1, "R4 deviation error", n_err - e0, 1);
        check(n_valid == v0, "R4 no valid", n_valid - v0, 0);
        check(bit_period == 16, "R4 period held", bit_period, 16);
    endtask

    task automatic t_bit7;
        int v0 = n_valid, e0 = n_err;
        int iv[8] = '{16, 16, 16, 16, 16, 16, 16, 16};
        send_body(iv);
        seg(1'b0, 4);
        seg(1'b1, 60);
        check(n_err - e0 == 1, "R7 bit7 high error", n_err - e0, 1);
        check(n_valid == v0, "R7 no valid", n_valid - v0, 0);
    endtask

    task automatic t_stop;
        int v0 = n_valid, e0 = n_err;
        int iv[8] = '{16, 16, 16, 16, 16, 16, 16, 16};
        send_body(iv);
        seg(1'b0, 16);
        seg(1'b0, 16);
        seg(1'b1, 60);
        check(n_err - e0 == 1, "R6 stop low error", n_err - e0, 1);
        check(n_valid == v0, "R6 no valid", n_valid - v0, 0);
    endtask

    task automatic t_min;
        int v0 = n_valid, e0 = n_err;
        send_uniform(3);
        seg(1'b1, 20);
        check(n_err - e0 == 1, "R8 short period error", n_err - e0, 1);
        check(n_valid == v0, "R8 no valid", n_valid - v0, 0);
        check(bit_period == 16, "R8 period held", bit_period, 16);
    endtask

    task automatic t_stuck;
        int v0 = n_valid, e0 = n_err;
        seg(1'b0, 1100);
        check(n_err - e0 == 1, "R5 saturation error", n_err - e0, 1);
        check(n_valid == v0, "R5 no valid", n_valid - v0, 0);
        seg(1'b1, 20);
        send_uniform(12);
        check(n_valid - v0 == 1, "R9 rearm valid", n_valid - v0, 1);
        check(seen_period == 12, "R9 rearm period", seen_period, 12);
        check(n_err - e0 == 1, "R9 no extra error", n_err - e0, 1);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_retime();
        t_uneven();
        t_tol();
        t_bit7();
        t_stop();
        t_min();
        t_stuck();
        check(n_both == 0, "R11 strobes exclusive", n_both, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule